// File: doc/BRIEF.md
# Last-In First-Out Register Stack with Occupancy Flags

This block is a 64-entry last-in first-out store for words of parametrizable width. A 6-bit pointer addresses the storage. A push moves the pointer up first and then writes the incoming word at the new address. A pop reads the word at the current address into an output register and then moves the pointer down. Occupancy is not kept in a separate counter. The two flags come only from the pointer returning to zero: after the 64th push the pointer has wrapped to address 0, which holds that last word, and the stack is full. When a pop brings the pointer back to 0, the stack is empty.

Requests that cannot be served are ignored and produce a one-cycle error pulse. These are a push into a full stack, a pop from an empty stack, and a push and a pop in the same cycle. The popped word stays on its output until the next accepted pop replaces it.

Top module: `stack_top`

## Requirements
- R1: After synchronous reset, `stackPtr` is 0, `empty` is 1, `full` is 0, `reqErr` is 0 and `popData` is 0.
- R2: An accepted push (push=1, pop=0, full=0) increments `stackPtr` by one modulo 64, stores `pushData` at the new pointer value, and clears `empty`. All of this is visible after the next rising edge.
- R3: When an accepted push wraps `stackPtr` from 63 to 0, `full` becomes 1. This happens on the 64th push into an empty stack.
- R4: An accepted pop (pop=1, push=0, empty=0) loads the word stored at the current `stackPtr` into `popData`, decrements `stackPtr` by one modulo 64, and clears `full`. All of this is visible after the next rising edge.
- R5: When an accepted pop leaves `stackPtr` at 0, `empty` becomes 1.
- R6: A push while `full` is 1 leaves `stackPtr`, the flags and the stored words unchanged. `reqErr` is 1 for exactly the following cycle.
- R7: A pop while `empty` is 1 leaves `stackPtr`, the flags and `popData` unchanged. `reqErr` is 1 for exactly the following cycle.
- R8: A push and a pop asserted in the same cycle have no effect on `stackPtr`, the flags, `popData` or the stored words. `reqErr` is 1 for exactly the following cycle.
- R9: `popData` keeps its value through every cycle without an accepted pop.
- R10: Words come back in the reverse of the order in which they were pushed, across a full fill and drain of all 64 entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Push request strobe |
| pop | input | 1 | Pop request strobe |
| pushData | input | W | Word to push |
| popData | output | W | Last popped word, held |
| stackPtr | output | AW (6) | Current stack pointer |
| full | output | 1 | Stack holds 64 words |
| empty | output | 1 | Stack holds no words |
| reqErr | output | 1 | One-cycle pulse after a rejected request |

## Verification
Every result is a register output, so the response to a request presented in one cycle appears after exactly one rising edge. This covers the pointer, both flags, the popped word and the error pulse. The bench drives each request at a falling edge, waits for the next falling edge, and compares all five outputs against a model updated from the requirements. An idle cycle follows the error cases to confirm that the pulse lasts one cycle and that `popData` is held. A full fill and drain compares the popped words against the arithmetic pattern used for pushing, in reverse order.

// File: rtl/stack_pkg.sv
package stack_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;   // write pushData at stackPtr+1
    logic rdEn;   // capture word at stackPtr into popData
  } stackStrobe_t;
endpackage

// File: rtl/stack_dp.sv
module stack_dp
  import stack_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  stackStrobe_t  strobe,
  input  logic [AW-1:0] ptr,
  input  logic [W-1:0]  wrData,
  output logic [W-1:0]  rdData
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wrAddr;

  // pre-increment addressing for writes
  assign wrAddr = ptr + AW'(1);

  always_ff @(posedge clk) begin
    if (strobe.wrEn) store[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst)              rdData <= '0;
    else if (strobe.rdEn) rdData <= store[ptr];
  end
endmodule

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import stack_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output stackStrobe_t  strobe,
  output logic [AW-1:0] ptr,
  output logic          full,
  output logic          empty,
  output logic          reqErr
);
  logic          pushOnly, popOnly, pushOk, popOk, rejected;
  logic [AW-1:0] ptrUp, ptrDown;

  assign pushOnly = push & ~pop;
  assign popOnly  = pop & ~push;
  assign pushOk   = pushOnly & ~full;
  assign popOk    = popOnly & ~empty;
  assign rejected = (push & pop) | (pushOnly & full) | (popOnly & empty);
  assign ptrUp    = ptr + AW'(1);
  assign ptrDown  = ptr - AW'(1);

  always_comb begin
    strobe.wrEn = pushOk;
    strobe.rdEn = popOk;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
      reqErr <= 1'b0;
    end else begin
      reqErr <= rejected;
      if (pushOk) begin
        ptr   <= ptrUp;
        empty <= 1'b0;
        if (ptrUp == '0) full <= 1'b1;
      end else if (popOk) begin
        ptr  <= ptrDown;
        full <= 1'b0;
        if (ptrDown == '0) empty <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/stack_top.sv
module stack_top
  import stack_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  pushData,
  output logic [W-1:0]  popData,
  output logic [AW-1:0] stackPtr,
  output logic          full,
  output logic          empty,
  output logic          reqErr
);
  stackStrobe_t strobe;

  stack_ctrl #(.AW(AW)) uCtrl (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .strobe(strobe), .ptr(stackPtr), .full(full), .empty(empty), .reqErr(reqErr)
  );

  stack_dp #(.W(W), .AW(AW)) uDp (
    .clk(clk), .rst(rst), .strobe(strobe), .ptr(stackPtr),
    .wrData(pushData), .rdData(popData)
  );
endmodule

// File: rtl/stack_chk.sv
module stack_chk #(
  parameter int W  = 8,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          push,
  input logic          pop,
  input logic [W-1:0]  popData,
  input logic [AW-1:0] stackPtr,
  input logic          full,
  input logic          empty,
  input logic          reqErr
);
  // R3 R5
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({full, empty}));

  // R2
  push_moves_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !full) |=> (stackPtr == $past(stackPtr) + AW'(1)) && !empty && !reqErr);

  // R4
  pop_moves_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !empty) |=> (stackPtr == $past(stackPtr) - AW'(1)) && !full && !reqErr);

  // R8
  both_rejected_chk: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> reqErr && $stable(stackPtr) && $stable(full) && $stable(empty));

  // R6
  push_full_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && full) |=> reqErr && $stable(stackPtr) && full);

  // R7
  pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && empty) |=> reqErr && $stable(stackPtr) && empty);

  // R9
  pop_data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(pop && !push && !empty) |=> $stable(popData));
endmodule

bind stack_top stack_chk #(.W(W), .AW(AW)) uChk (
  .clk(clk), .rst(rst), .push(push), .pop(pop), .popData(popData),
  .stackPtr(stackPtr), .full(full), .empty(empty), .reqErr(reqErr)
);

// File: tb/sim_stack_top.sv
module sim_stack_top;
  localparam int PERIOD = 10;
  localparam int W      = 8;
  localparam int AW     = 6;
  localparam int DEPTH  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst, push, pop;
  logic [W-1:0]  pushData;
  logic [W-1:0]  popData;
  logic [AW-1:0] stackPtr;
  logic          full, empty, reqErr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference state, derived from the requirements
  logic [W-1:0]  mMem [DEPTH];
  logic [AW-1:0] mPtr;
  logic          mFull, mEmpty, mErr;
  logic [W-1:0]  mOut;

  always #(PERIOD/2) clk = ~clk;

  stack_top #(.W(W), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .pushData(pushData),
    .popData(popData), .stackPtr(stackPtr), .full(full), .empty(empty), .reqErr(reqErr)
  );

  function automatic logic [W-1:0] pat(input int i);
    return W'(i * 37 + 11);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chkAll(input string req);
    chk(req, "stackPtr", int'(stackPtr), int'(mPtr));
    chk(req, "full",     int'(full),     int'(mFull));
    chk(req, "empty",    int'(empty),    int'(mEmpty));
    chk(req, "reqErr",   int'(reqErr),   int'(mErr));
    chk(req, "popData",  int'(popData),  int'(mOut));
  endtask

  // present one request at a falling edge, check one cycle later
  task automatic op(input logic p, input logic q, input logic [W-1:0] d, input string req);
    push = p; pop = q; pushData = d;
    mErr = 1'b0;
    if (p && q) mErr = 1'b1;
    else if (p) begin
      if (mFull) mErr = 1'b1;
      else begin
        mPtr = mPtr + AW'(1);
        mMem[mPtr] = d;
        mEmpty = 1'b0;
        if (mPtr == '0) mFull = 1'b1;
      end
    end else if (q) begin
      if (mEmpty) mErr = 1'b1;
      else begin
        mOut = mMem[mPtr];
        mPtr = mPtr - AW'(1);
        mFull = 1'b0;
        if (mPtr == '0) mEmpty = 1'b1;
      end
    end
    @(negedge clk);
    push = 1'b0; pop = 1'b0;
    chkAll(req);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; push = 1'b0; pop = 1'b0; pushData = '0;
    mPtr = '0; mFull = 1'b0; mEmpty = 1'b1; mErr = 1'b0; mOut = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chkAll("R1");

    // R7: pop from empty stack after reset
    op(1'b0, 1'b1, '0, "R7");
    op(1'b0, 1'b0, '0, "R7");
    // R8 on an empty stack
    op(1'b1, 1'b1, 8'hA5, "R8");

    // R2 R3: fill all entries
    for (int i = 0; i < DEPTH; i++)
      op(1'b1, 1'b0, pat(i), (i == DEPTH - 1) ? "R3" : "R2");
    chk("R3", "full after 64 pushes", int'(full), 1);

    // R6: push while full, then idle to see the pulse end
    op(1'b1, 1'b0, 8'h3C, "R6");
    op(1'b0, 1'b0, '0, "R6");
    // R8 while full
    op(1'b1, 1'b1, 8'h3C, "R8");

    // R4 R5 R10: drain, words in reverse push order
    for (int k = 0; k < DEPTH; k++) begin
      op(1'b0, 1'b1, '0, (k == DEPTH - 1) ? "R5" : "R4");
      chk("R10", "popped word", int'(popData), int'(pat(DEPTH - 1 - k)));
    end
    chk("R5", "empty after drain", int'(empty), 1);
    op(1'b0, 1'b1, '0, "R7");

    // R9: interleaved traffic with holds
    op(1'b1, 1'b0, 8'h11, "R2");
    op(1'b1, 1'b0, 8'h22, "R2");
    op(1'b0, 1'b1, '0, "R4");
    op(1'b0, 1'b0, '0, "R9");
    op(1'b1, 1'b0, 8'h33, "R9");
    op(1'b1, 1'b1, 8'h44, "R8");
    op(1'b0, 1'b0, '0, "R9");
    op(1'b0, 1'b1, '0, "R4");
    op(1'b0, 1'b1, '0, "R5");
    op(1'b0, 1'b0, '0, "R9");

    // second full cycle exercises wrap again with a different offset
    for (int i = 0; i < DEPTH; i++) op(1'b1, 1'b0, pat(i + 100), "R3");
    for (int k = 0; k < DEPTH; k++) begin
      op(1'b0, 1'b1, '0, "R4");
      chk("R10", "popped word", int'(popData), int'(pat(DEPTH - 1 - k + 100)));
    end

    // R1: reset mid-traffic
    op(1'b1, 1'b0, 8'h77, "R2");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mPtr = '0; mFull = 1'b0; mEmpty = 1'b1; mErr = 1'b0; mOut = '0;
    chkAll("R1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule